// File: doc/BRIEF.md
# SIMD Register Region Address Generator

This block turns the operand description of one SIMD instruction into the byte addresses that the execution pipe needs in order to read or write the general register file. The register file is an array of 32-byte registers. An operand names a register, a byte offset inside that register, an element type size and a two-dimensional region. The region has a row pitch (vertical stride), a row length (width) and an element pitch inside a row (horizontal stride). The block computes the operand's starting byte offset, the effective region shape, and one address and one enable per channel.

The block also makes the split decision. An instruction whose destination footprint (channel count times destination element size) reaches 64 bytes is executed as two halves, each with half the channels, unless the instruction is a message send, which is never split. A half-select input picks which half is being issued, and that choice moves the operand's starting point. A source region whose row pitch equals its row length with unit element pitch is collapsed into a single contiguous vector. A destination is always addressed as a contiguous vector. A destination that asks for an element pitch above one is marked unsupported.

The computation is combinational from the request to a single output register stage. A pulse on `req_valid` produces a result one cycle later, marked by `out_valid`.

Top module: `grf_region_addrgen`

## Requirements
- R1: `out_valid` is high in exactly the cycle after a cycle with `req_valid` high. Every result field is captured from the request presented with that pulse.
- R2: The channel count is 2 to the power `req_exec_log2`. If the count times 2^`req_dst_tlog2` bytes is 64 or more and `req_no_split` is 0, then `out_split` is 1 and `out_exec_log2` is `req_exec_log2`-1. Otherwise `out_split` is 0 and `out_exec_log2` equals `req_exec_log2`.
- R3: The channel start is half the full channel count when `out_split` is 1 and `req_half` is 1. Otherwise it is 0, so `req_half` has no effect on an unsplit instruction.
- R4: The subregister byte offset comes from `req_sub_a16` when `req_align16` is 1 and from `req_sub_a1` when it is 0.
- R5: For a source (`req_is_dst`=0), `out_base` = regnum·32 + subregister offset + (start div 2^`req_width_log2`) · vstride · 2^`req_tlog2`, taken modulo 2^16.
- R6: For a source, if vstride equals 2^`req_width_log2` and hstride is 1, then `out_vstride` is the effective channel count and `out_width_log2` is `out_exec_log2`. Otherwise the shape fields pass through unchanged.
- R7: For channel i below the effective count, `out_lane_en[i]` is 1. Its address in `out_addr[16i+15:16i]` is base + (i div W)·V·T + (i mod W)·H·T, where W, V and H are the output shape and T = 2^`req_tlog2`. Channels at or above the count have enable 0 and address 0.
- R8: For a destination, `out_base` = regnum·32 + subregister offset + start · hstride · 2^`req_tlog2`. The destination shape is vstride = width = effective channel count, with hstride 1.
- R9: `out_unsupported` is 1 only for a destination whose requested hstride is greater than 1. It is always 0 for a source.
- R10: After reset, `out_valid`, `out_base`, `out_lane_en` and `out_addr` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe |
| req_is_dst | input | 1 | 1 = destination operand, 0 = source |
| req_align16 | input | 1 | Access mode: 1 selects the align16 subregister field |
| req_regnum | input | 7 | Register number |
| req_sub_a1 | input | 5 | Subregister byte offset, align1 encoding |
| req_sub_a16 | input | 5 | Subregister byte offset, align16 encoding |
| req_tlog2 | input | 2 | log2 of the operand element size in bytes |
| req_dst_tlog2 | input | 2 | log2 of the instruction's destination element size |
| req_vstride | input | 6 | Vertical stride in elements |
| req_width_log2 | input | 3 | log2 of the region width |
| req_hstride | input | 3 | Horizontal stride in elements |
| req_exec_log2 | input | 3 | Execution size field |
| req_no_split | input | 1 | 1 for message sends, which are never split |
| req_half | input | 1 | Selects the second half of a split instruction |
| out_valid | output | 1 | Result valid |
| out_split | output | 1 | Instruction executes as two halves |
| out_exec_log2 | output | 3 | log2 of the effective channel count |
| out_base | output | 16 | Operand start byte offset |
| out_vstride | output | 6 | Effective vertical stride |
| out_width_log2 | output | 3 | log2 of the effective width |
| out_hstride | output | 3 | Effective horizontal stride |
| out_unsupported | output | 1 | Destination region not supported |
| out_lane_en | output | 32 | Per-channel enable |
| out_addr | output | 512 | Per-channel byte address, 16 bits per channel |

## Verification
The bench builds the block with its default parameters: 32-byte registers, up to 32 channels, 16-bit addresses and a 64-byte split threshold. With these values, 16 channels of 4-byte data and 32 channels of 2-byte data both land exactly on the split boundary, and a message send of the same size stays whole. Both halves of a split operand are issued, so the row offset of a strided source and the shifted start of a destination can be observed. Collapsed and strided sources, scalar regions and regions wider than the channel count exercise the lane formula, including the disabled upper lanes.

// File: rtl/grf_region_pkg.sv
package grf_region_pkg;

  // Byte offset of a channel inside a 2D region, relative to the region base.
  function automatic int unsigned lane_offset(input int unsigned lane,
                                              input int unsigned wlog2,
                                              input int unsigned vs,
                                              input int unsigned hs,
                                              input int unsigned tlog2);
    int unsigned row;
    int unsigned col;
    row = lane >> wlog2;
    col = lane & ((32'd1 << wlog2) - 32'd1);
    return (row * vs + col * hs) << tlog2;
  endfunction

  // Source start: whole rows skipped by the channel start, scaled by vstride.
  function automatic int unsigned src_base(input int unsigned regnum,
                                           input int unsigned grf_log2,
                                           input int unsigned sub,
                                           input int unsigned start,
                                           input int unsigned wlog2,
                                           input int unsigned vs,
                                           input int unsigned tlog2);
    return (regnum << grf_log2) + sub + (((start >> wlog2) * vs) << tlog2);
  endfunction

  // Destination start: channel start scaled by the element pitch.
  function automatic int unsigned dst_base(input int unsigned regnum,
                                           input int unsigned grf_log2,
                                           input int unsigned sub,
                                           input int unsigned start,
                                           input int unsigned hs,
                                           input int unsigned tlog2);
    return (regnum << grf_log2) + sub + ((start * hs) << tlog2);
  endfunction

  // Two-half execution is needed when the destination footprint reaches the limit.
  function automatic logic needs_split(input int unsigned exec_log2,
                                       input int unsigned dtlog2,
                                       input int unsigned limit,
                                       input logic        no_split);
    return ((32'd1 << (exec_log2 + dtlog2)) >= limit) && !no_split;
  endfunction

endpackage

// File: rtl/grf_region_shape.sv
module grf_region_shape
  import grf_region_pkg::*;
#(
  parameter int REG_W       = 7,
  parameter int SUB_W       = 5,
  parameter int TL_W        = 2,
  parameter int VS_W        = 6,
  parameter int HS_W        = 3,
  parameter int WL_W        = 3,
  parameter int EL_W        = 3,
  parameter int AW          = 16,
  parameter int GRF_LOG2    = 5,
  parameter int SPLIT_BYTES = 64
) (
  input  logic             is_dst,
  input  logic             align16,
  input  logic [REG_W-1:0] regnum,
  input  logic [SUB_W-1:0] sub_a1,
  input  logic [SUB_W-1:0] sub_a16,
  input  logic [TL_W-1:0]  tlog2,
  input  logic [TL_W-1:0]  dtlog2,
  input  logic [VS_W-1:0]  vstride,
  input  logic [WL_W-1:0]  wlog2,
  input  logic [HS_W-1:0]  hstride,
  input  logic [EL_W-1:0]  exec_log2,
  input  logic             no_split,
  input  logic             half,
  output logic             split,
  output logic [EL_W-1:0]  eff_exec_log2,
  output logic [AW-1:0]    base,
  output logic [VS_W-1:0]  eff_vstride,
  output logic [WL_W-1:0]  eff_wlog2,
  output logic [HS_W-1:0]  eff_hstride,
  output logic             unsupported
);

  logic [SUB_W-1:0] sub_sel;
  logic             collapse;
  logic             contiguous;
  int unsigned      exec_n;
  int unsigned      start_lane;
  int unsigned      base_full;

  // Subregister field chosen by access mode.
  assign sub_sel = align16 ? sub_a16 : sub_a1;

  always_comb begin
    exec_n        = 32'd1 << exec_log2;
    split         = needs_split(32'(exec_log2), 32'(dtlog2), 32'(SPLIT_BYTES), no_split);
    eff_exec_log2 = split ? exec_log2 - EL_W'(1) : exec_log2;
    start_lane    = (split && half) ? (exec_n >> 1) : 32'd0;
  end

  // Source region equivalent to one flat vector.
  assign collapse   = !is_dst && (32'(vstride) == (32'd1 << wlog2)) && (hstride == HS_W'(1));
  assign contiguous = is_dst || collapse;

  always_comb begin
    if (is_dst)
      base_full = dst_base(32'(regnum), 32'(GRF_LOG2), 32'(sub_sel), start_lane,
                           32'(hstride), 32'(tlog2));
    else
      base_full = src_base(32'(regnum), 32'(GRF_LOG2), 32'(sub_sel), start_lane,
                           32'(wlog2), 32'(vstride), 32'(tlog2));
  end
  assign base = AW'(base_full);

  assign eff_vstride = contiguous ? VS_W'(32'd1 << eff_exec_log2) : vstride;
  assign eff_wlog2   = contiguous ? WL_W'(eff_exec_log2) : wlog2;
  assign eff_hstride = is_dst ? HS_W'(1) : hstride;
  assign unsupported = is_dst && (hstride > HS_W'(1));

endmodule

// File: rtl/grf_region_lanes.sv
module grf_region_lanes
  import grf_region_pkg::*;
#(
  parameter int MAX_EXEC = 32,
  parameter int AW       = 16,
  parameter int TL_W     = 2,
  parameter int VS_W     = 6,
  parameter int HS_W     = 3,
  parameter int WL_W     = 3,
  parameter int EL_W     = 3
) (
  input  logic [AW-1:0]          base,
  input  logic [EL_W-1:0]        eff_exec_log2,
  input  logic [VS_W-1:0]        vstride,
  input  logic [WL_W-1:0]        wlog2,
  input  logic [HS_W-1:0]        hstride,
  input  logic [TL_W-1:0]        tlog2,
  output logic [MAX_EXEC-1:0]    lane_en,
  output logic [MAX_EXEC*AW-1:0] lane_addr
);

  for (genvar g = 0; g < MAX_EXEC; g++) begin : g_lane
    int unsigned ofs;
    assign lane_en[g] = (32'(g) < (32'd1 << eff_exec_log2));
    assign ofs = lane_offset(32'(g), 32'(wlog2), 32'(vstride), 32'(hstride), 32'(tlog2));
    assign lane_addr[g*AW +: AW] = lane_en[g] ? (base + AW'(ofs)) : '0;
  end

endmodule

// File: rtl/grf_region_addrgen.sv
module grf_region_addrgen
  import grf_region_pkg::*;
#(
  parameter int REG_W         = 7,
  parameter int SUB_W         = 5,
  parameter int TL_W          = 2,
  parameter int VS_W          = 6,
  parameter int HS_W          = 3,
  parameter int WL_W          = 3,
  parameter int EL_W          = 3,
  parameter int MAX_EXEC_LOG2 = 5,
  parameter int AW            = 16,
  parameter int GRF_LOG2      = 5,
  parameter int SPLIT_BYTES   = 64,
  localparam int MAX_EXEC     = 1 << MAX_EXEC_LOG2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic                   req_is_dst,
  input  logic                   req_align16,
  input  logic [REG_W-1:0]       req_regnum,
  input  logic [SUB_W-1:0]       req_sub_a1,
  input  logic [SUB_W-1:0]       req_sub_a16,
  input  logic [TL_W-1:0]        req_tlog2,
  input  logic [TL_W-1:0]        req_dst_tlog2,
  input  logic [VS_W-1:0]        req_vstride,
  input  logic [WL_W-1:0]        req_width_log2,
  input  logic [HS_W-1:0]        req_hstride,
  input  logic [EL_W-1:0]        req_exec_log2,
  input  logic                   req_no_split,
  input  logic                   req_half,
  output logic                   out_valid,
  output logic                   out_split,
  output logic [EL_W-1:0]        out_exec_log2,
  output logic [AW-1:0]          out_base,
  output logic [VS_W-1:0]        out_vstride,
  output logic [WL_W-1:0]        out_width_log2,
  output logic [HS_W-1:0]        out_hstride,
  output logic                   out_unsupported,
  output logic [MAX_EXEC-1:0]    out_lane_en,
  output logic [MAX_EXEC*AW-1:0] out_addr
);

  // Named internal events between the shape stage and the lane stage.
  logic                   shp_split;
  logic [EL_W-1:0]        shp_exec_log2;
  logic [AW-1:0]          shp_base;
  logic [VS_W-1:0]        shp_vstride;
  logic [WL_W-1:0]        shp_wlog2;
  logic [HS_W-1:0]        shp_hstride;
  logic                   shp_unsup;
  logic [MAX_EXEC-1:0]    ln_en;
  logic [MAX_EXEC*AW-1:0] ln_addr;
  logic                   r_is_dst;

  grf_region_shape #(
    .REG_W(REG_W), .SUB_W(SUB_W), .TL_W(TL_W), .VS_W(VS_W), .HS_W(HS_W),
    .WL_W(WL_W), .EL_W(EL_W), .AW(AW), .GRF_LOG2(GRF_LOG2),
    .SPLIT_BYTES(SPLIT_BYTES)
  ) shape_i (
    .is_dst        (req_is_dst),
    .align16       (req_align16),
    .regnum        (req_regnum),
    .sub_a1        (req_sub_a1),
    .sub_a16       (req_sub_a16),
    .tlog2         (req_tlog2),
    .dtlog2        (req_dst_tlog2),
    .vstride       (req_vstride),
    .wlog2         (req_width_log2),
    .hstride       (req_hstride),
    .exec_log2     (req_exec_log2),
    .no_split      (req_no_split),
    .half          (req_half),
    .split         (shp_split),
    .eff_exec_log2 (shp_exec_log2),
    .base          (shp_base),
    .eff_vstride   (shp_vstride),
    .eff_wlog2     (shp_wlog2),
    .eff_hstride   (shp_hstride),
    .unsupported   (shp_unsup)
  );

  grf_region_lanes #(
    .MAX_EXEC(MAX_EXEC), .AW(AW), .TL_W(TL_W), .VS_W(VS_W), .HS_W(HS_W),
    .WL_W(WL_W), .EL_W(EL_W)
  ) lanes_i (
    .base          (shp_base),
    .eff_exec_log2 (shp_exec_log2),
    .vstride       (shp_vstride),
    .wlog2         (shp_wlog2),
    .hstride       (shp_hstride),
    .tlog2         (req_tlog2),
    .lane_en       (ln_en),
    .lane_addr     (ln_addr)
  );

  // Result stage: one register between request and result.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid       <= 1'b0;
      out_split       <= 1'b0;
      out_exec_log2   <= '0;
      out_base        <= '0;
      out_vstride     <= '0;
      out_width_log2  <= '0;
      out_hstride     <= '0;
      out_unsupported <= 1'b0;
      out_lane_en     <= '0;
      out_addr        <= '0;
      r_is_dst        <= 1'b0;
    end else begin
      out_valid <= req_valid;
      if (req_valid) begin
        out_split       <= shp_split;
        out_exec_log2   <= shp_exec_log2;
        out_base        <= shp_base;
        out_vstride     <= shp_vstride;
        out_width_log2  <= shp_wlog2;
        out_hstride     <= shp_hstride;
        out_unsupported <= shp_unsup;
        out_lane_en     <= ln_en;
        out_addr        <= ln_addr;
        r_is_dst        <= req_is_dst;
      end
    end
  end

  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> out_valid);

  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !out_valid);

  // R2
  split_halves_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (out_split ? (out_exec_log2 == $past(req_exec_log2) - EL_W'(1))
                             : (out_exec_log2 == $past(req_exec_log2))));

  // R7
  lane_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ($countones(out_lane_en) == (32'd1 << out_exec_log2)));

  // R7
  lane_zero_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_lane_en[0]) |-> (out_addr[AW-1:0] == out_base));

  // R9
  unsup_dst_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_unsupported) |-> (r_is_dst && out_hstride == HS_W'(1)));

endmodule

// File: tb/grf_region_addrgen_tb_top.sv
module grf_region_addrgen_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        req_valid = 0, req_is_dst = 0, req_align16 = 0, req_no_split = 0, req_half = 0;
  logic [6:0]  req_regnum = 0;
  logic [4:0]  req_sub_a1 = 0, req_sub_a16 = 0;
  logic [1:0]  req_tlog2 = 0, req_dst_tlog2 = 0;
  logic [5:0]  req_vstride = 0;
  logic [2:0]  req_width_log2 = 0, req_hstride = 0, req_exec_log2 = 0;
  logic        out_valid, out_split, out_unsupported;
  logic [2:0]  out_exec_log2, out_width_log2, out_hstride;
  logic [15:0] out_base;
  logic [5:0]  out_vstride;
  logic [31:0] out_lane_en;
  logic [511:0] out_addr;

  grf_region_addrgen dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_is_dst(req_is_dst),
    .req_align16(req_align16), .req_regnum(req_regnum), .req_sub_a1(req_sub_a1),
    .req_sub_a16(req_sub_a16), .req_tlog2(req_tlog2), .req_dst_tlog2(req_dst_tlog2),
    .req_vstride(req_vstride), .req_width_log2(req_width_log2), .req_hstride(req_hstride),
    .req_exec_log2(req_exec_log2), .req_no_split(req_no_split), .req_half(req_half),
    .out_valid(out_valid), .out_split(out_split), .out_exec_log2(out_exec_log2),
    .out_base(out_base), .out_vstride(out_vstride), .out_width_log2(out_width_log2),
    .out_hstride(out_hstride), .out_unsupported(out_unsupported),
    .out_lane_en(out_lane_en), .out_addr(out_addr)
  );

  typedef struct packed {
    logic [15:0]  base;
    logic         split;
    logic [2:0]   el;
    logic [5:0]   vs;
    logic [5:0]   w;
    logic [2:0]   hs;
    logic         unsup;
    logic [31:0]  en;
    logic [511:0] addr;
  } exp_t;

  exp_t  expq[$];
  string tagq[$];
  int    n_chk = 0;
  int    n_bad = 0;
  bit    done = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // Driver: computes the expected result from the requirements and queues it.
  task automatic drive(input bit dst, input bit a16, input int rg, input int s1, input int s16,
                       input int tl, input int dtl, input int vs, input int wl, input int hs,
                       input int el, input bit ns, input bit hf, input string tag);
    exp_t e;
    int exec, eexec, start, sub, ts, w, ev, ew, eh, b;
    exec  = 1 << el;
    e.split = (exec * (1 << dtl) >= 64) && !ns;
    eexec = e.split ? exec / 2 : exec;
    start = (e.split && hf) ? eexec : 0;
    sub   = a16 ? s16 : s1;
    ts    = 1 << tl;
    w     = 1 << wl;
    if (dst) begin
      b = rg * 32 + sub + start * hs * ts;
      ev = eexec; ew = eexec; eh = 1;
      e.unsup = (hs > 1);
    end else begin
      b = rg * 32 + sub + (start / w) * vs * ts;
      if (vs == w && hs == 1) begin ev = eexec; ew = eexec; end
      else begin ev = vs; ew = w; end
      eh = hs;
      e.unsup = 0;
    end
    e.base = 16'(b);
    e.el = 3'(e.split ? el - 1 : el);
    e.vs = 6'(ev); e.w = 6'(ew); e.hs = 3'(eh);
    e.en = '0; e.addr = '0;
    for (int i = 0; i < 32; i++) begin
      if (i < eexec) begin
        e.en[i] = 1'b1;
        e.addr[i*16 +: 16] = 16'(b + (i / ew) * ev * ts + (i % ew) * eh * ts);
      end
    end
    @(negedge clk);
    req_valid = 1; req_is_dst = dst; req_align16 = a16; req_regnum = 7'(rg);
    req_sub_a1 = 5'(s1); req_sub_a16 = 5'(s16); req_tlog2 = 2'(tl); req_dst_tlog2 = 2'(dtl);
    req_vstride = 6'(vs); req_width_log2 = 3'(wl); req_hstride = 3'(hs);
    req_exec_log2 = 3'(el); req_no_split = ns; req_half = hf;
    @(posedge clk);
    expq.push_back(e);
    tagq.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 0;
    end
  endtask

  // Monitor: compares each result against the head of the queue.
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(out_valid == (expq.size() > 0), "R1 valid timing", 32'(out_valid), 32'(expq.size() > 0));
      if (out_valid && expq.size() > 0) begin
        exp_t  e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        chk(out_base == e.base, t, 32'(out_base), 32'(e.base));
        chk(out_split == e.split, "R2 split", 32'(out_split), 32'(e.split));
        chk(out_exec_log2 == e.el, "R2 exec", 32'(out_exec_log2), 32'(e.el));
        chk(out_vstride == e.vs, "R6/R8 vstride", 32'(out_vstride), 32'(e.vs));
        chk((32'd1 << out_width_log2) == 32'(e.w), "R6/R8 width", 32'd1 << out_width_log2, 32'(e.w));
        chk(out_hstride == e.hs, "R6/R8 hstride", 32'(out_hstride), 32'(e.hs));
        chk(out_unsupported == e.unsup, "R9 unsupported", 32'(out_unsupported), 32'(e.unsup));
        chk(out_lane_en == e.en, "R7 lane enables", out_lane_en, e.en);
        for (int i = 0; i < 32; i++)
          chk(out_addr[i*16 +: 16] == e.addr[i*16 +: 16], "R7 lane address",
              32'(out_addr[i*16 +: 16]), 32'(e.addr[i*16 +: 16]));
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(out_valid == 0 && out_base == 0, "R10 reset valid/base", {15'd0, out_valid, out_base}, 32'd0);
    chk(out_lane_en == 0 && out_addr == '0, "R10 reset lanes", out_lane_en, 32'd0);
    rst_n = 1;
    idle(2);
    // R5 R6 contiguous source <8;8,1>, 8 lanes of 4 bytes: collapses
    drive(0, 0, 3, 8, 0, 2, 2, 8, 3, 1, 3, 0, 0, "R5 src base");
    // R6 strided source <8;4,2>, 2-byte elements: stays 2D
    drive(0, 0, 5, 2, 0, 1, 1, 8, 2, 2, 3, 0, 0, "R6 strided src base");
    idle(1);
    // R4 align16 subregister selection
    drive(0, 1, 2, 4, 16, 2, 2, 4, 2, 1, 2, 0, 0, "R4 align16 sub");
    drive(0, 0, 2, 4, 16, 2, 2, 4, 2, 1, 2, 0, 0, "R4 align1 sub");
    // R2 R3 16 lanes x 4 bytes = 64: split, both halves, source <8;4,1>
    drive(0, 0, 10, 0, 0, 2, 2, 8, 2, 1, 4, 0, 0, "R3 first half");
    drive(0, 0, 10, 0, 0, 2, 2, 8, 2, 1, 4, 0, 1, "R3 second half row offset");
    // R8 destination second half
    drive(1, 0, 20, 4, 0, 2, 2, 0, 0, 1, 4, 0, 1, "R8 dst second half");
    // R2 message send never split
    drive(0, 0, 1, 0, 0, 2, 2, 16, 4, 1, 4, 1, 0, "R2 send no split base");
    // R3 half ignored when not split
    drive(1, 0, 7, 0, 0, 2, 2, 0, 0, 1, 3, 0, 1, "R3 half ignored");
    // R2 32 lanes x 2 bytes = 64: split
    drive(1, 0, 30, 0, 0, 1, 1, 0, 0, 1, 5, 0, 1, "R8 dst 32x2 split");
    // R9 destination hstride 2
    drive(1, 0, 4, 0, 0, 1, 1, 0, 0, 2, 3, 0, 0, "R9 dst hstride 2");
    // R7 scalar region <0;1,0>
    drive(0, 0, 9, 12, 0, 2, 2, 0, 0, 0, 3, 0, 0, "R7 scalar src");
    // R7 width wider than channel count, 8-byte elements
    drive(0, 0, 6, 0, 0, 3, 3, 16, 3, 2, 2, 0, 0, "R7 wide region");
    // R9 source with hstride 4 not flagged
    drive(0, 0, 11, 0, 0, 0, 0, 16, 2, 4, 3, 0, 0, "R9 src hstride 4 base");
    idle(4);
    chk(expq.size() == 0, "R1 all results seen", 32'(expq.size()), 32'd0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule